// File: doc/BRIEF.md
# Banked Data Register File with Pointer Indirection

This block is the data memory of a small 8-bit controller core. The datapath presents a 7-bit file address taken from the instruction. The block turns that address into a physical byte location and returns its contents on a combinational read port. A separate write port commits data on the rising clock edge. The memory holds four banks of 128 bytes. Direct accesses pick the bank with a two-bit field of the status register. A pseudo-register at offset 00h makes the access indirect: the target is a 9-bit address formed from the top status bit followed by the 8-bit pointer register.

In every bank, offsets 00h to 1Fh are control locations. Offsets 20h to 7Fh are general storage. The status register (offset 03h), the pointer register (04h) and the pseudo-register (00h) are the same registers whichever bank is selected. Offsets 70h to 7Fh are one shared 16-byte region, so every bank reaches the bank 0 bytes there. In banks 2 and 3, offsets 20h to 6Fh are not implemented. The other control offsets are plain bytes, one set per bank.

The status register also receives the ALU flag updates. When an instruction both writes the status register and updates flags, the flag logic has priority over the data for the three flag bits. The timeout and power-down bits are never taken from written data.

Top module: `rf_banked_file`

## Requirements
- R1: A direct access to an offset other than 00h, 03h, 04h or the shared region reaches the byte of bank `status[6:5]` at that offset. Each bank keeps its own contents.
- R2: Offsets 70h–7Fh reach the same 16 bytes from every bank, so a write made in any bank is read back in all four.
- R3: In banks 2 and 3, offsets 20h–6Fh read as 00h, and writes to them change nothing.
- R4: Offset 03h is the status register, 04h is the pointer register and 00h is the indirect pseudo-register in every bank.
- R5: An access to offset 00h targets effective address `{status[7], pointer}`. Bits 8:7 of that address select the bank and bits 6:0 select the offset, and the target is then decoded as in R1–R4.
- R6: An indirect access whose target offset is 00h reads 00h. A write through it changes no state.
- R7: A status write in a cycle where `flag_we` is nonzero does not load bits 2:0 from the data. Each flag bit with its `flag_we` bit set takes `flag_val`. The other flag bits keep their values.
- R8: A status write with `flag_we` = 000 loads bits 7:5 and 2:0 from the written data.
- R9: Status bits 4 (timeout) and 3 (power-down) are 1 after reset and no write changes them.
- R10: After reset the status register reads 18h, the pointer reads 00h and every storage byte reads 00h.
- R11: Reads are combinational from `rd_addr`. A write takes effect at the clock edge, so a read of the same location in the write cycle returns the old value.
- R12: The flag bits selected by `flag_we` (bit 0 carry, bit 1 digit carry, bit 2 zero) take `flag_val` at the edge even when the write goes to some other location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr | input | 7 | File address of the read operand |
| rd_data | output | 8 | Read data, combinational |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_addr | input | 7 | File address of the destination |
| wr_data | input | 8 | Data to write |
| flag_we | input | 3 | Flags the instruction updates (bit0 C, bit1 DC, bit2 Z) |
| flag_val | input | 3 | New values for the updated flags |

## Verification
The bench writes a distinct pattern to every plain offset of every bank and then reads back all 512 addresses. A design that did not share the 70h–7Fh region, or that stored data in the holes of banks 2 and 3, would return the wrong byte there. It then walks all 512 effective addresses through the pointer. A mistake in the address concatenation, or an indirect read at target offset 00h that did not return zero, would give the wrong value. It also writes the status register with clashing data and flag updates. A design where the data beat the flag logic, or where the timeout and power-down bits could be written, would read back a different status byte. Finally, it reads a location in the same cycle it is written. A design that forwarded the new data early would show it one cycle too soon.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Decoded class of a resolved access
    typedef enum logic [1:0] {
        LOC_NONE,     // unimplemented, or pseudo-register reached through itself
        LOC_STATUS,
        LOC_POINTER,
        LOC_STORE
    } loc_kind_e;

    // Fixed offsets visible in every bank
    localparam logic [6:0] OFS_PSEUDO  = 7'h00;
    localparam logic [6:0] OFS_STATUS  = 7'h03;
    localparam logic [6:0] OFS_POINTER = 7'h04;

    // Status register bit positions
    localparam int ST_C       = 0;
    localparam int ST_DC      = 1;
    localparam int ST_Z       = 2;
    localparam int ST_PD      = 3;
    localparam int ST_TO      = 4;
    localparam int ST_BANK_LO = 5;
    localparam int ST_IND_HI  = 7;
    localparam int FLAG_W     = 3;

    localparam logic [7:0] STATUS_RESET = 8'h18;

endpackage

// File: rtl/rf_addr_resolve.sv
module rf_addr_resolve
    import rf_pkg::*;
#(
    parameter int BANK_BITS   = 2,
    parameter int OFS_BITS    = 7,
    parameter int DATA_W      = 8,
    parameter int SFR_SPAN    = 32,
    parameter int COMMON_BASE = 112,
    parameter int GPR_BANKS   = 2,
    localparam int PHYS_BITS  = BANK_BITS + OFS_BITS
) (
    input  logic [OFS_BITS-1:0]  file_addr,
    input  logic [BANK_BITS-1:0] bank_sel,
    input  logic                 ind_hi,
    input  logic [DATA_W-1:0]    ptr,
    output loc_kind_e            kind,
    output logic [PHYS_BITS-1:0] phys
);

    logic                 indirect;
    logic [PHYS_BITS-1:0] ea;
    logic [BANK_BITS-1:0] bank;
    logic [OFS_BITS-1:0]  ofs;

    always_comb begin
        indirect = (file_addr == OFS_BITS'(OFS_PSEUDO));
        ea       = PHYS_BITS'({ind_hi, ptr});
        bank     = indirect ? ea[PHYS_BITS-1 -: BANK_BITS] : bank_sel;
        ofs      = indirect ? ea[OFS_BITS-1:0] : file_addr;
        phys     = {bank, ofs};

        if (ofs == OFS_BITS'(OFS_PSEUDO)) begin
            kind = LOC_NONE;               // self-reference through the pointer
        end else if (ofs == OFS_BITS'(OFS_STATUS)) begin
            kind = LOC_STATUS;
        end else if (ofs == OFS_BITS'(OFS_POINTER)) begin
            kind = LOC_POINTER;
        end else if (int'(ofs) >= COMMON_BASE) begin
            kind = LOC_STORE;
            phys = {{BANK_BITS{1'b0}}, ofs}; // shared region lives in bank 0
        end else if (int'(ofs) >= SFR_SPAN && int'(bank) >= GPR_BANKS) begin
            kind = LOC_NONE;
        end else begin
            kind = LOC_STORE;
        end
    end

endmodule

// File: rtl/rf_ctrl_regs.sv
module rf_ctrl_regs
    import rf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              status_hit,
    input  logic              pointer_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FLAG_W-1:0] flag_we,
    input  logic [FLAG_W-1:0] flag_val,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] ptr_q
);

    logic [DATA_W-1:0] status_d;

    always_comb begin
        status_d = status_q;
        if (status_hit) begin
            status_d[ST_IND_HI:ST_BANK_LO] = wr_data[ST_IND_HI:ST_BANK_LO];
            if (flag_we == '0) begin
                status_d[ST_Z:ST_C] = wr_data[ST_Z:ST_C];
            end
        end
        for (int i = 0; i < FLAG_W; i++) begin
            if (flag_we[i]) begin
                status_d[ST_C + i] = flag_val[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= DATA_W'(STATUS_RESET);
            ptr_q    <= '0;
        end else begin
            status_q <= status_d;
            if (pointer_hit) begin
                ptr_q <= wr_data;
            end
        end
    end

endmodule

// File: rtl/rf_store.sv
module rf_store #(
    parameter int PHYS_BITS = 9,
    parameter int DATA_W    = 8,
    localparam int DEPTH    = 1 << PHYS_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [PHYS_BITS-1:0] waddr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [PHYS_BITS-1:0] raddr,
    output logic [DATA_W-1:0]    rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rf_banked_file.sv
module rf_banked_file
    import rf_pkg::*;
#(
    parameter int BANK_BITS   = 2,
    parameter int OFS_BITS    = 7,
    parameter int DATA_W      = 8,
    parameter int SFR_SPAN    = 32,
    parameter int COMMON_BASE = 112,
    parameter int GPR_BANKS   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OFS_BITS-1:0] rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                wr_en,
    input  logic [OFS_BITS-1:0] wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [FLAG_W-1:0]   flag_we,
    input  logic [FLAG_W-1:0]   flag_val
);

    localparam int PHYS_BITS = BANK_BITS + OFS_BITS;

    logic [DATA_W-1:0]    status_q;
    logic [DATA_W-1:0]    ptr_q;
    loc_kind_e            rd_kind;
    loc_kind_e            wr_kind;
    logic [PHYS_BITS-1:0] rd_phys;
    logic [PHYS_BITS-1:0] wr_phys;
    logic [DATA_W-1:0]    store_rdata;
    logic [BANK_BITS-1:0] bank_sel;

    assign bank_sel = status_q[ST_BANK_LO +: BANK_BITS];

    rf_addr_resolve #(
        .BANK_BITS(BANK_BITS), .OFS_BITS(OFS_BITS), .DATA_W(DATA_W),
        .SFR_SPAN(SFR_SPAN), .COMMON_BASE(COMMON_BASE), .GPR_BANKS(GPR_BANKS)
    ) i_rd_resolve (
        .file_addr(rd_addr),
        .bank_sel (bank_sel),
        .ind_hi   (status_q[ST_IND_HI]),
        .ptr      (ptr_q),
        .kind     (rd_kind),
        .phys     (rd_phys)
    );

    rf_addr_resolve #(
        .BANK_BITS(BANK_BITS), .OFS_BITS(OFS_BITS), .DATA_W(DATA_W),
        .SFR_SPAN(SFR_SPAN), .COMMON_BASE(COMMON_BASE), .GPR_BANKS(GPR_BANKS)
    ) i_wr_resolve (
        .file_addr(wr_addr),
        .bank_sel (bank_sel),
        .ind_hi   (status_q[ST_IND_HI]),
        .ptr      (ptr_q),
        .kind     (wr_kind),
        .phys     (wr_phys)
    );

    rf_ctrl_regs #(.DATA_W(DATA_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_hit (wr_en && (wr_kind == LOC_STATUS)),
        .pointer_hit(wr_en && (wr_kind == LOC_POINTER)),
        .wr_data    (wr_data),
        .flag_we    (flag_we),
        .flag_val   (flag_val),
        .status_q   (status_q),
        .ptr_q      (ptr_q)
    );

    rf_store #(.PHYS_BITS(PHYS_BITS), .DATA_W(DATA_W)) i_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_en && (wr_kind == LOC_STORE)),
        .waddr(wr_phys),
        .wdata(wr_data),
        .raddr(rd_phys),
        .rdata(store_rdata)
    );

    always_comb begin
        unique case (rd_kind)
            LOC_STATUS:  rd_data = status_q;
            LOC_POINTER: rd_data = ptr_q;
            LOC_STORE:   rd_data = store_rdata;
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/rf_banked_file_chk.sv
module rf_banked_file_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] rd_addr,
    input logic [7:0] rd_data,
    input logic       wr_en,
    input logic [6:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [2:0] flag_we,
    input logic [2:0] flag_val,
    input logic [7:0] status_q,
    input logic [7:0] ptr_q
);

    assert_unimpl_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[6:5] >= 2'd2 && rd_addr >= 7'h20 && rd_addr < 7'h70) |-> rd_data == 8'h00);

    assert_status_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 7'h03) |-> rd_data == status_q);

    assert_pointer_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 7'h04) |-> rd_data == ptr_q);

    assert_self_indirect_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 7'h00 && ptr_q[6:0] == 7'h00) |-> rd_data == 8'h00);

    assert_flag_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 7'h03 && flag_we[0]) |=> status_q[0] == $past(flag_val[0]));

    assert_flag_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 7'h03 && flag_we != 3'b000 && !flag_we[2])
        |=> status_q[2] == $past(status_q[2]));

    assert_status_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 7'h03 && flag_we == 3'b000)
        |=> (status_q[7:5] == $past(wr_data[7:5]) && status_q[2:0] == $past(wr_data[2:0])));

    assert_to_pd_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 7'h03) |=> status_q[4:3] == 2'b11);

endmodule

bind rf_banked_file rf_banked_file_chk i_rf_banked_file_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .flag_we (flag_we),
    .flag_val(flag_val),
    .status_q(status_q),
    .ptr_q   (ptr_q)
);

// File: tb/test_rf_banked_file.sv
module test_rf_banked_file;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wr_en = 1'b0;
    logic [6:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] flag_we = '0;
    logic [2:0] flag_val = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_mem [512];
    logic [7:0] m_st;
    logic [7:0] m_ptr;

    rf_banked_file i_rf_banked_file (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .flag_we(flag_we), .flag_val(flag_val)
    );

    always #2.5ns clk = ~clk;

    // Physical slot for plain storage, -1 for a hole (R1, R2, R3)
    function automatic int locate(int b, int o);
        if (o >= 'h70) return o;
        if (o >= 'h20 && b >= 2) return -1;
        return b * 128 + o;
    endfunction

    function automatic logic [7:0] read_at(int b, int o);
        int loc;
        if (o == 3) return m_st;
        if (o == 4) return m_ptr;
        loc = locate(b, o);
        if (loc < 0) return 8'h00;
        return m_mem[loc];
    endfunction

    function automatic logic [7:0] model_read(int a);
        int b;
        int o;
        if (a == 0) begin
            b = {m_st[7], m_ptr[7]};
            o = int'(m_ptr[6:0]);
            if (o == 0) return 8'h00;
            return read_at(b, o);
        end
        return read_at(int'(m_st[6:5]), a);
    endfunction

    task automatic model_write(int a, logic [7:0] d, logic [2:0] fw, logic [2:0] fv);
        int b;
        int o;
        int loc;
        bit skip = 1'b0;
        if (a == 0) begin
            b = {m_st[7], m_ptr[7]};
            o = int'(m_ptr[6:0]);
            if (o == 0) skip = 1'b1;
        end else begin
            b = int'(m_st[6:5]);
            o = a;
        end
        if (!skip) begin
            if (o == 3) begin
                m_st[7:5] = d[7:5];
                if (fw == 3'b000) m_st[2:0] = d[2:0];
            end else if (o == 4) begin
                m_ptr = d;
            end else begin
                loc = locate(b, o);
                if (loc >= 0) m_mem[loc] = d;
            end
        end
        for (int i = 0; i < 3; i++) if (fw[i]) m_st[i] = fv[i];
    endtask

    task automatic do_write(int a, logic [7:0] d, logic [2:0] fw, logic [2:0] fv);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'(a); wr_data = d; flag_we = fw; flag_val = fv;
        @(posedge clk);
        #1ns;
        wr_en = 1'b0; flag_we = '0;
        model_write(a, d, fw, fv);
    endtask

    task automatic check_read(int a, string tag);
        logic [7:0] exp;
        @(negedge clk);
        rd_addr = 7'(a);
        #1ns;
        exp = model_read(a);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s addr=%02h status=%02h ptr=%02h actual=%02h expected=%02h",
                     tag, a, m_st, m_ptr, rd_data, exp);
        end
    endtask

    task automatic set_bank(int b);
        do_write(3, {m_st[7], 2'(b), 2'b00, m_st[2:0]}, 3'b000, 3'b000);
    endtask

    task automatic verify_all();
        for (int b = 0; b < 4; b++) begin
            set_bank(b);
            for (int o = 0; o < 128; o++) begin
                if (o == 0 || o == 3 || o == 4) check_read(o, "R4");
                else if (o >= 'h70)             check_read(o, "R2");
                else if (o >= 'h20 && b >= 2)   check_read(o, "R3");
                else                            check_read(o, "R1");
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 512; i++) m_mem[i] = 8'h00;
        m_st  = 8'h18;
        m_ptr = 8'h00;
        repeat (3) @(posedge clk);
        #1ns rst_n = 1'b1;

        // R10: reset values
        check_read(3, "R10");
        check_read(4, "R10");
        check_read(7'h25, "R10");
        check_read(7'h75, "R10");

        // R1 R2 R3: distinct pattern into every plain offset of every bank
        for (int b = 0; b < 4; b++) begin
            set_bank(b);
            for (int o = 1; o < 128; o++) begin
                if (o != 3 && o != 4)
                    do_write(o, 8'((b * 37 + o * 5 + 1)), 3'b000, 3'b000);
            end
        end
        verify_all();

        // R5 R6: sweep every effective address through the pointer
        for (int ea = 0; ea < 512; ea++) begin
            do_write(4, 8'(ea), 3'b000, 3'b000);
            do_write(3, {1'(ea >> 8), m_st[6:0]}, 3'b000, 3'b000);
            if ((ea & 'h7F) == 0) check_read(0, "R6");
            else                  check_read(0, "R5");
        end

        // R5: indirect write into bank 1 GPR, read back directly
        do_write(3, 8'h00, 3'b000, 3'b000);
        do_write(4, 8'hB9, 3'b000, 3'b000);
        do_write(0, 8'h5C, 3'b000, 3'b000);
        set_bank(1);
        check_read(7'h39, "R5");
        // R5: indirect write reaching the status register
        do_write(3, 8'h80, 3'b000, 3'b000);
        do_write(4, 8'h03, 3'b000, 3'b000);
        do_write(0, 8'h47, 3'b000, 3'b000);
        check_read(3, "R5");

        // R6: write through the pseudo-register to itself changes nothing
        do_write(3, 8'h00, 3'b000, 3'b000);
        do_write(4, 8'h80, 3'b000, 3'b000);
        do_write(0, 8'hEE, 3'b000, 3'b000);
        check_read(3, "R6");
        check_read(4, "R6");
        check_read(0, "R6");
        verify_all();

        // R7: flags beat written data
        do_write(3, 8'hFF, 3'b101, 3'b010);
        check_read(3, "R7");
        do_write(3, 8'h07, 3'b010, 3'b000);
        check_read(3, "R7");
        // R8 R9: plain status write, timeout/power-down untouched
        do_write(3, 8'h00, 3'b000, 3'b000);
        check_read(3, "R9");
        do_write(3, 8'h27, 3'b000, 3'b000);
        check_read(3, "R8");
        // R12: flag update while writing elsewhere
        do_write(7'h40, 8'h6D, 3'b111, 3'b101);
        check_read(3, "R12");
        check_read(7'h40, "R12");

        // R11: same-cycle read returns old data, new after the edge
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'h50; wr_data = 8'h99; flag_we = '0;
        rd_addr = 7'h50;
        #1ns;
        checks++;
        if (rd_data !== model_read('h50)) begin
            fails++;
            $display("FAIL R11 before edge actual=%02h expected=%02h", rd_data, model_read('h50));
        end
        @(posedge clk);
        #1ns;
        wr_en = 1'b0;
        model_write('h50, 8'h99, 3'b000, 3'b000);
        check_read(7'h50, "R11");

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #1ms;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule